// File: doc/BRIEF.md
# Parallel Bitstream Configuration Master

This block pushes a configuration byte stream into a target device over an 8-bit parallel configuration port, and can also read the device contents back. It drives the device's program request, chip-select, write-enable, configuration clock and data lines. It samples the device's init, busy and done status lines. Every step of the port sequence moves on a divided tick, so one tick is one half-period of the configuration clock. `HALF_DIV` sets the divider. Pick it so that the configuration clock stays at or below 50 MHz. Each byte on the data lines is then held for at least one half-period before its rising edge.

A load starts with a pulse on the program request. The block then waits until the device reports ready, and asserts write-enable followed by chip-select. It accepts bytes from a valid/ready input stream and gives each byte one clock pulse. With `BUSY_CHK` set, the block stalls on the busy line after each byte. At the end it releases the strobes and clocks the device until the done line rises. Any wait that exceeds `TMO_TICKS` half-periods stops the operation, raises the abort output and reports an error. A readback clocks `len_i` bytes out of the device onto a one-cycle output strobe. The operation length comes from `len_i`, sampled at start, and a completion pulse with an error flag closes every operation.

Top module: `pcfg_master`

## Requirements
- R1: After reset the port is idle: program, chip-select and write-enable low, configuration clock high, `in_ready_o`, `fin_o` and `abort_o` low.
- R2: On a load start (`start_i` with `mode_i`=0), the program request is high for exactly `HALF_DIV` cycles and is never high together with chip-select. Write-enable does not rise until `cfg_init_i` is high and `cfg_busy_i` is low.
- R3: If the device is not ready within `TMO_TICKS` half-periods, the block aborts. `abort_o` and `err_o` are 1 with `fin_o`, chip-select is never asserted, and the strobes end low with the clock high.
- R4: Write-enable rises one half-period before chip-select, and both are asserted with the configuration clock high. `in_ready_o` is only high in this state.
- R5: Each accepted byte is presented on `cfg_data_o` and receives exactly one low-then-high clock pulse. Bytes go out in arrival order, and the data lines never change while the clock is low.
- R6: With busy checking on, if `cfg_busy_i` is high after a byte's rising edge, the block sends extra clock pulses with no new data until busy drops. Each half-period pair of busy gives one pulse.
- R7: If busy stays high, the block aborts after `TMO_TICKS`-1 stall pulses and takes no further byte (`err_o`=1, `abort_o`=1).
- R8: After the last byte, chip-select is released one half-period before write-enable.
- R9: After write-enable falls, the block pulses the clock until `cfg_done_i` is high, then finishes with `err_o`=0. If done never comes, it aborts after `TMO_TICKS`-1 pulses.
- R10: A readback (`mode_i`=1) asserts chip-select with the clock high and sends `len_i` pulses. After each rising edge it captures `cfg_data_i` and presents it on `out_data_o` with a one-cycle `out_valid_o`, in order.
- R11: A readback ends by releasing chip-select and then sending exactly one more clock pulse. It finishes with `err_o`=0.
- R12: A load with `len_i`=0 sends no data pulse and goes straight from chip-select assertion to the release sequence.
- R13: `fin_o` is a one-cycle pulse. `abort_o` rises together with `fin_o` and `err_o`, stays high after the operation, and clears when the next operation starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start an operation (taken while idle) |
| mode_i | input | 1 | 0 = load, 1 = readback |
| len_i | input | LEN_W | Byte count of the operation |
| in_data_i | input | 8 | Load byte stream data |
| in_valid_i | input | 1 | Load byte stream valid |
| in_ready_o | output | 1 | Load byte stream ready |
| out_data_o | output | 8 | Readback byte |
| out_valid_o | output | 1 | Readback byte strobe, one cycle |
| fin_o | output | 1 | Operation finished, one cycle |
| err_o | output | 1 | Operation failed, valid with fin_o |
| abort_o | output | 1 | Timeout abort indication, held |
| cfg_prog_o | output | 1 | Program request to device |
| cfg_cs_o | output | 1 | Chip-select to device |
| cfg_wr_o | output | 1 | Write-enable to device |
| cfg_clk_o | output | 1 | Configuration clock |
| cfg_data_o | output | 8 | Configuration data to device |
| cfg_data_i | input | 8 | Readback data from device |
| cfg_init_i | input | 1 | Device init status, high = ready |
| cfg_busy_i | input | 1 | Device busy status |
| cfg_done_i | input | 1 | Device done status |

## Verification
The hardest case to reach is a busy stall that never ends in the middle of a load, while the next byte is already waiting on the input stream. It only occurs when the device model raises busy on the exact rising edge that delivers a chosen byte and then holds it. The bench's device model counts data edges and sets busy at a programmed byte index, either for a fixed number of stall pulses or indefinitely. Its input feeder keeps the following byte valid and gives up only when the operation finishes, so the check confirms that the stall pulses carry no new byte and that the abort comes after the expected pulse count.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  typedef enum logic [4:0] {
    ST_IDLE, ST_PROG, ST_WAIT, ST_SEL, ST_FETCH, ST_LOW, ST_HIGH,
    ST_BCHK, ST_BLOW, ST_END_CS, ST_END_WR, ST_DCHK, ST_DLOW,
    ST_RB_SEL, ST_RB_LOW, ST_RB_HIGH, ST_RB_CAP, ST_RB_END, ST_RB_XL, ST_RB_XH
  } pcfg_state_e;
endpackage

// File: rtl/pcfg_tick.sv
module pcfg_tick #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pcfg_timer.sv
module pcfg_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned TW = $clog2(LIMIT) + 1;
  logic [TW-1:0] cnt_q;

  assign last_o = (cnt_q == TW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pcfg_master.sv
module pcfg_master
  import pcfg_pkg::*;
#(
  parameter int unsigned HALF_DIV  = 2,
  parameter int unsigned TMO_TICKS = 500000,
  parameter int unsigned LEN_W     = 16,
  parameter bit          BUSY_CHK  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       in_data_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  output logic [7:0]       out_data_o,
  output logic             out_valid_o,
  output logic             fin_o,
  output logic             err_o,
  output logic             abort_o,
  output logic             cfg_prog_o,
  output logic             cfg_cs_o,
  output logic             cfg_wr_o,
  output logic             cfg_clk_o,
  output logic [7:0]       cfg_data_o,
  input  logic [7:0]       cfg_data_i,
  input  logic             cfg_init_i,
  input  logic             cfg_busy_i,
  input  logic             cfg_done_i
);
  pcfg_state_e      state_q, post_byte_st;
  logic [LEN_W-1:0] cnt_q;
  logic             prog_q, cs_q, wr_q, clk_q, fin_q, err_q, abort_q, rd_vld_q;
  logic [7:0]       data_q, rd_q;
  logic             tick, start_acc, dev_ready, stall_c, fail_c;
  logic             tmr_clr, tmr_inc, tmr_last;

  assign start_acc = start_i && (state_q == ST_IDLE);
  assign dev_ready = cfg_init_i && !cfg_busy_i;

  pcfg_tick #(.HALF_DIV(HALF_DIV)) i_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(start_acc), .tick_o(tick)
  );

  // stall_c: a wait state whose exit condition is not yet met
  always_comb begin
    stall_c = ((state_q == ST_WAIT) && !dev_ready)
           || ((state_q == ST_BCHK) && cfg_busy_i)
           || ((state_q == ST_DCHK) && !cfg_done_i);
    tmr_clr = start_acc || (tick && ((state_q == ST_HIGH) || (state_q == ST_END_WR)));
    tmr_inc = tick && stall_c;
    fail_c  = tick && stall_c && tmr_last;
  end

  pcfg_timer #(.LIMIT(TMO_TICKS)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tmr_clr), .inc_i(tmr_inc), .last_o(tmr_last)
  );

  if (BUSY_CHK) begin : g_busy
    assign post_byte_st = ST_BCHK;
  end else begin : g_nobusy
    assign post_byte_st = (cnt_q == LEN_W'(1)) ? ST_END_CS : ST_FETCH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      prog_q   <= 1'b0;
      cs_q     <= 1'b0;
      wr_q     <= 1'b0;
      clk_q    <= 1'b1;
      data_q   <= '0;
      rd_q     <= '0;
      rd_vld_q <= 1'b0;
      fin_q    <= 1'b0;
      err_q    <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      fin_q    <= 1'b0;
      rd_vld_q <= 1'b0;
      if (fail_c) begin
        state_q <= ST_IDLE;
        prog_q  <= 1'b0;
        cs_q    <= 1'b0;
        wr_q    <= 1'b0;
        clk_q   <= 1'b1;
        fin_q   <= 1'b1;
        err_q   <= 1'b1;
        abort_q <= 1'b1;
      end else begin
        case (state_q)
          ST_IDLE: if (start_i) begin
            abort_q <= 1'b0;
            err_q   <= 1'b0;
            cnt_q   <= len_i;
            if (mode_i) state_q <= ST_RB_SEL;
            else begin
              prog_q  <= 1'b1;
              state_q <= ST_PROG;
            end
          end
          ST_FETCH: if (in_valid_i) begin
            data_q  <= in_data_i;
            state_q <= ST_LOW;
          end
          default: if (tick) begin
            case (state_q)
              ST_PROG: begin prog_q <= 1'b0; state_q <= ST_WAIT; end
              ST_WAIT: if (dev_ready) begin wr_q <= 1'b1; state_q <= ST_SEL; end
              ST_SEL: begin
                cs_q    <= 1'b1;
                state_q <= (cnt_q == '0) ? ST_END_CS : ST_FETCH;
              end
              ST_LOW:  begin clk_q <= 1'b0; state_q <= ST_HIGH; end
              ST_HIGH: begin
                clk_q   <= 1'b1;
                cnt_q   <= cnt_q - LEN_W'(1);
                state_q <= post_byte_st;
              end
              ST_BCHK: begin
                if (cfg_busy_i) begin clk_q <= 1'b0; state_q <= ST_BLOW; end
                else state_q <= (cnt_q == '0) ? ST_END_CS : ST_FETCH;
              end
              ST_BLOW:   begin clk_q <= 1'b1; state_q <= ST_BCHK; end
              ST_END_CS: begin cs_q <= 1'b0; state_q <= ST_END_WR; end
              ST_END_WR: begin wr_q <= 1'b0; state_q <= ST_DCHK; end
              ST_DCHK: begin
                if (cfg_done_i) begin fin_q <= 1'b1; state_q <= ST_IDLE; end
                else begin clk_q <= 1'b0; state_q <= ST_DLOW; end
              end
              ST_DLOW: begin clk_q <= 1'b1; state_q <= ST_DCHK; end
              ST_RB_SEL: begin
                cs_q    <= 1'b1;
                state_q <= (cnt_q == '0) ? ST_RB_END : ST_RB_LOW;
              end
              ST_RB_LOW:  begin clk_q <= 1'b0; state_q <= ST_RB_HIGH; end
              ST_RB_HIGH: begin clk_q <= 1'b1; state_q <= ST_RB_CAP; end
              ST_RB_CAP: begin
                rd_q     <= cfg_data_i;
                rd_vld_q <= 1'b1;
                cnt_q    <= cnt_q - LEN_W'(1);
                state_q  <= (cnt_q == LEN_W'(1)) ? ST_RB_END : ST_RB_LOW;
              end
              ST_RB_END: begin cs_q <= 1'b0; state_q <= ST_RB_XL; end
              ST_RB_XL:  begin clk_q <= 1'b0; state_q <= ST_RB_XH; end
              ST_RB_XH: begin
                clk_q   <= 1'b1;
                fin_q   <= 1'b1;
                state_q <= ST_IDLE;
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        endcase
      end
    end
  end

  assign in_ready_o  = (state_q == ST_FETCH);
  assign out_data_o  = rd_q;
  assign out_valid_o = rd_vld_q;
  assign fin_o       = fin_q;
  assign err_o       = err_q;
  assign abort_o     = abort_q;
  assign cfg_prog_o  = prog_q;
  assign cfg_cs_o    = cs_q;
  assign cfg_wr_o    = wr_q;
  assign cfg_clk_o   = clk_q;
  assign cfg_data_o  = data_q;
endmodule

// File: rtl/pcfg_master_chk.sv
module pcfg_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_prog_o,
  input logic       cfg_cs_o,
  input logic       cfg_wr_o,
  input logic       cfg_clk_o,
  input logic [7:0] cfg_data_o,
  input logic       in_ready_o,
  input logic       out_valid_o,
  input logic       fin_o,
  input logic       err_o,
  input logic       abort_o
);
  assert_prog_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_prog_o |-> !cfg_cs_o);

  assert_ready_strobes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (cfg_cs_o && cfg_wr_o && cfg_clk_o));

  assert_data_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_clk_o |-> $stable(cfg_data_o));

  assert_cs_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_wr_o) |-> !cfg_cs_o);

  assert_capture_phase_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (cfg_cs_o && cfg_clk_o));

  assert_abort_flags_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> (fin_o && err_o));
endmodule

bind pcfg_master pcfg_master_chk i_pcfg_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_prog_o(cfg_prog_o), .cfg_cs_o(cfg_cs_o),
  .cfg_wr_o(cfg_wr_o), .cfg_clk_o(cfg_clk_o), .cfg_data_o(cfg_data_o),
  .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .fin_o(fin_o),
  .err_o(err_o), .abort_o(abort_o)
);

// File: tb/test_pcfg_master.sv
module test_pcfg_master;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int TMO  = 20;
  localparam int LW   = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, mode_i = 1'b0;
  logic [LW-1:0] len_i = '0;
  logic [7:0] in_data_i = '0;
  logic in_valid_i = 1'b0;
  logic in_ready_o, out_valid_o, fin_o, err_o, abort_o;
  logic [7:0] out_data_o, cfg_data_o;
  logic cfg_prog_o, cfg_cs_o, cfg_wr_o, cfg_clk_o;
  logic [7:0] cfg_data_i = '0;
  logic cfg_init_i = 1'b0, cfg_busy_i = 1'b0, cfg_done_i = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pcfg_master #(.HALF_DIV(HALF), .TMO_TICKS(TMO), .LEN_W(LW), .BUSY_CHK(1'b1)) i_pcfg_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i), .len_i(len_i),
    .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .fin_o(fin_o), .err_o(err_o),
    .abort_o(abort_o), .cfg_prog_o(cfg_prog_o), .cfg_cs_o(cfg_cs_o), .cfg_wr_o(cfg_wr_o),
    .cfg_clk_o(cfg_clk_o), .cfg_data_o(cfg_data_o), .cfg_data_i(cfg_data_i),
    .cfg_init_i(cfg_init_i), .cfg_busy_i(cfg_busy_i), .cfg_done_i(cfg_done_i)
  );

  // test configuration, written by the main process only
  logic [7:0] exp_arr [16];
  logic [7:0] rb_arr  [16];
  int  cur_mode = 0, busy_at = 0, busy_len = 0, done_after = 0, op_id = 0;
  bit  init_en = 1'b1, op_over = 1'b0;
  int  tb_chk = 0, tb_fail = 0;

  // device model and reference, written by the monitor only
  int  mon_chk = 0, mon_fail = 0, seen_id = 0;
  int  data_pulses, stall_pulses, done_pulses, rb_pulses, rb_extra, cs_rises;
  int  byte_idx, stall_left, rb_wr, rb_rd, prog_w;
  bit  done_phase;
  logic p_clk = 1'b1, p_cs = 1'b0, p_wr = 1'b0;
  logic [7:0] last_byte;

  task automatic mchk(input bit ok, input string req, input int act, input int exp);
    mon_chk++;
    if (!ok) begin
      mon_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tchk(input bit ok, input string req, input int act, input int exp);
    tb_chk++;
    if (!ok) begin
      tb_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (op_id != seen_id) begin
        seen_id = op_id;
        data_pulses = 0; stall_pulses = 0; done_pulses = 0; rb_pulses = 0;
        rb_extra = 0; cs_rises = 0; byte_idx = 0; stall_left = 0;
        rb_wr = 0; rb_rd = 0; done_phase = 1'b0;
        cfg_busy_i = 1'b0; cfg_done_i = 1'b0;
      end
      cfg_init_i = init_en && !cfg_prog_o;
      if (cfg_prog_o) prog_w++;
      else if (prog_w > 0) begin
        mchk(prog_w == HALF, "R2 program pulse width", prog_w, HALF);
        prog_w = 0;
      end
      if (cfg_wr_o && !p_wr) begin
        mchk(!cfg_cs_o && cfg_clk_o, "R4 wr before cs, clk high", int'(cfg_cs_o), 0);
        mchk(cfg_init_i && !cfg_busy_i, "R2 wr only after ready", int'(cfg_init_i), 1);
      end
      if (cfg_cs_o && !p_cs) begin
        cs_rises++;
        mchk(cfg_clk_o == 1'b1, "R4/R10 cs rises with clk high", int'(cfg_clk_o), 1);
        mchk(cfg_wr_o == (cur_mode == 0), "R4/R10 wr level at cs rise", int'(cfg_wr_o),
             int'(cur_mode == 0));
      end
      if (!cfg_wr_o && p_wr) begin
        mchk(!cfg_cs_o, "R8 cs released before wr", int'(cfg_cs_o), 0);
        done_phase = 1'b1;
        if (done_after == 0) cfg_done_i = 1'b1;
      end
      if (cfg_clk_o && !p_clk) begin
        if (cur_mode == 0) begin
          if (cfg_cs_o && cfg_wr_o) begin
            if (cfg_busy_i) begin
              stall_pulses++;
              mchk(cfg_data_o == last_byte, "R6 no new data on stall pulse", cfg_data_o, last_byte);
              stall_left--;
              if (stall_left == 0) cfg_busy_i = 1'b0;
            end else begin
              mchk(cfg_data_o == exp_arr[byte_idx], "R5 byte on data edge", cfg_data_o,
                   exp_arr[byte_idx]);
              last_byte = cfg_data_o;
              data_pulses++;
              byte_idx++;
              if (byte_idx == busy_at) begin
                cfg_busy_i = 1'b1;
                stall_left = busy_len;
              end
            end
          end else if (done_phase) begin
            done_pulses++;
            if (done_after > 0 && done_pulses == done_after) cfg_done_i = 1'b1;
          end else mchk(1'b0, "R5 stray clock pulse", 1, 0);
        end else begin
          if (cfg_cs_o) begin
            rb_pulses++;
            cfg_data_i = rb_arr[rb_wr];
            rb_wr++;
          end else rb_extra++;
        end
      end
      if (out_valid_o) begin
        mchk(out_data_o == rb_arr[rb_rd], "R10 readback byte", out_data_o, rb_arr[rb_rd]);
        rb_rd++;
      end
      p_clk = cfg_clk_o; p_cs = cfg_cs_o; p_wr = cfg_wr_o;
    end
  end

  bit fin_err, fin_abort, fin_seen;

  task automatic start_op(input bit m, input int n);
    @(negedge clk_i);
    cur_mode = m; op_id++; op_over = 1'b0;
    start_i = 1'b1; mode_i = m; len_i = LW'(n);
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_fin();
    int lim = 0;
    fin_seen = 1'b0;
    while (!fin_o && lim < 5000) begin @(negedge clk_i); lim++; end
    fin_seen = fin_o; fin_err = err_o; fin_abort = abort_o;
    tchk(fin_seen, "R13 operation finishes", int'(fin_seen), 1);
    @(negedge clk_i);
    tchk(!fin_o, "R13 fin is a single-cycle pulse", int'(fin_o), 0);
    op_over = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic feed(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      in_valid_i = 1'b1; in_data_i = exp_arr[i];
      while (!in_ready_o && !op_over) @(negedge clk_i);
      if (op_over) break;
      @(negedge clk_i);
      in_valid_i = 1'b0;
      repeat (gap) @(negedge clk_i);
    end
    in_valid_i = 1'b0;
  endtask

  task automatic run_load(input int n, input int gap, input int b_at, input int b_len,
                          input int d_after, input int init_delay);
    busy_at = b_at; busy_len = b_len; done_after = d_after;
    init_en = (init_delay == 0);
    start_op(1'b0, n);
    tchk(!abort_o, "R13 abort cleared by new start", int'(abort_o), 0);
    fork
      feed(n, gap);
      wait_fin();
      begin
        if (init_delay > 0) begin repeat (init_delay) @(negedge clk_i); init_en = 1'b1; end
      end
    join
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    tchk(!cfg_prog_o && !cfg_cs_o && !cfg_wr_o, "R1 strobes low in reset",
         int'({cfg_prog_o, cfg_cs_o, cfg_wr_o}), 0);
    tchk(cfg_clk_o, "R1 clock high in reset", int'(cfg_clk_o), 1);
    tchk(!in_ready_o && !fin_o && !abort_o, "R1 status low in reset",
         int'({in_ready_o, fin_o, abort_o}), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // plain load, back-to-back bytes, done after 3 pulses
    exp_arr[0] = 8'hA5; exp_arr[1] = 8'h3C; exp_arr[2] = 8'h01;
    exp_arr[3] = 8'hFF; exp_arr[4] = 8'h80;
    run_load(5, 0, 0, 0, 3, 0);
    tchk(!fin_err && !fin_abort, "R9 load succeeds", int'(fin_err), 0);
    tchk(data_pulses == 5, "R5 one pulse per byte", data_pulses, 5);
    tchk(done_pulses == 3, "R9 clocks until done", done_pulses, 3);
    tchk(stall_pulses == 0, "R6 no stall without busy", stall_pulses, 0);

    // load with gaps and a 3-pulse busy stall after byte 2
    exp_arr[0] = 8'h11; exp_arr[1] = 8'h22; exp_arr[2] = 8'h33; exp_arr[3] = 8'h44;
    run_load(4, 3, 2, 3, 0, 0);
    tchk(stall_pulses == 3, "R6 stall pulse count", stall_pulses, 3);
    tchk(data_pulses == 4, "R5 bytes with gaps", data_pulses, 4);
    tchk(done_pulses == 0 && !fin_err, "R9 done already high", done_pulses, 0);

    // zero length load
    run_load(0, 0, 0, 0, 1, 0);
    tchk(data_pulses == 0, "R12 no data pulse at length zero", data_pulses, 0);
    tchk(cs_rises == 1 && done_pulses == 1 && !fin_err, "R12 release sequence runs",
         cs_rises, 1);

    // device never ready
    exp_arr[0] = 8'h5A; exp_arr[1] = 8'h6B;
    busy_at = 0; busy_len = 0; done_after = 0; init_en = 1'b0;
    start_op(1'b0, 2);
    fork feed(2, 0); wait_fin(); join
    tchk(fin_err && fin_abort, "R3 init timeout aborts", int'({fin_err, fin_abort}), 3);
    tchk(cs_rises == 0 && data_pulses == 0, "R3 no chip-select", cs_rises, 0);
    tchk(!cfg_cs_o && !cfg_wr_o && cfg_clk_o, "R3 lines released",
         int'({cfg_cs_o, cfg_wr_o, cfg_clk_o}), 1);
    repeat (5) @(negedge clk_i);
    tchk(abort_o, "R13 abort held after operation", int'(abort_o), 1);

    // done never arrives
    exp_arr[0] = 8'h77; exp_arr[1] = 8'h88;
    run_load(2, 0, 0, 0, -1, 0);
    tchk(fin_err && fin_abort, "R9 done timeout aborts", int'({fin_err, fin_abort}), 3);
    tchk(done_pulses == TMO - 1, "R9 pulses before done abort", done_pulses, TMO - 1);

    // busy never clears after byte 1
    exp_arr[0] = 8'h9C; exp_arr[1] = 8'hD2; exp_arr[2] = 8'hE4;
    run_load(3, 0, 1, 1000, 0, 0);
    tchk(fin_err && fin_abort, "R7 busy timeout aborts", int'({fin_err, fin_abort}), 3);
    tchk(stall_pulses == TMO - 1, "R7 stall pulses before abort", stall_pulses, TMO - 1);
    tchk(data_pulses == 1, "R7 no byte taken after stall", data_pulses, 1);
    tchk(!cfg_cs_o && !cfg_wr_o, "R7 strobes released", int'({cfg_cs_o, cfg_wr_o}), 0);

    // readback of 4 bytes
    rb_arr[0] = 8'hC3; rb_arr[1] = 8'h0F; rb_arr[2] = 8'hF0; rb_arr[3] = 8'h5E;
    start_op(1'b1, 4);
    tchk(!abort_o, "R13 abort cleared by readback start", int'(abort_o), 0);
    wait_fin();
    tchk(!fin_err, "R11 readback succeeds", int'(fin_err), 0);
    tchk(rb_pulses == 4 && rb_rd == 4, "R10 readback pulses and bytes", rb_rd, 4);
    tchk(rb_extra == 1, "R11 one extra pulse after cs release", rb_extra, 1);

    // load where the device becomes ready late
    exp_arr[0] = 8'h42; exp_arr[1] = 8'h24;
    run_load(2, 1, 0, 0, 2, 12);
    tchk(!fin_err && data_pulses == 2, "R2 late ready then load", data_pulses, 2);

    // readback of zero bytes
    start_op(1'b1, 0);
    wait_fin();
    tchk(rb_pulses == 0 && rb_extra == 1 && !fin_err, "R11 empty readback", rb_extra, 1);

    $display("End of test - %0d assertions evaluated, %0d failures",
             tb_chk + mon_chk, tb_fail + mon_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures",
             tb_chk + mon_chk + 1, tb_fail + mon_fail + 1);
    $finish;
  end
endmodule